// File: doc/BRIEF.md
# Converter control and status register

This block is the byte-wide control and status register of a sampling converter's control logic. A host reaches it over a microprocessor-style bus: an active-low chip select, active-low read and write strobes, a register-select line and a byte-enable line. The register holds four mode bits: the output latch mode, the trigger-pin function, power down, and a calibration request that starts a calibration when written. Beside these it reports calibration in progress, busy, and two sticky error flags: supply failure and calibration overflow.

Event inputs come from the conversion sequencer (calibration running, conversion running, calibration overflow) and from a supply monitor (supply failed). When the supply comes back after a failure, the mode bits are reset and a calibration is requested automatically. Some write patterns are reserved, and the block drops them without any change of state. The bus inputs are sampled on the block clock. A write takes effect on the clock edge where the write strobe is seen rising while chip select is low.

Top module: `conv_ctrl_reg`

## Requirements
- R1: After reset the latch-mode, trigger-mode and power-down bits and both sticky flags are 0, `cal_start` is 0, and a valid read returns 0x00 while the sequencer inputs are idle.
- R2: A write is accepted only on the clock edge where `wr_n` is seen going from 0 to 1 with `cs_n` low, `reg_sel` high and `byte_en` high. It loads bit 0 (1 = latched output, 0 = transparent), bit 2 (1 = trigger pin times sample-to-hold, 0 = trigger pin starts calibration) and bit 3 (1 = power down). A write with `reg_sel` low, with `byte_en` low, or with `cs_n` high changes nothing.
- R3: While `cs_n`, `rd_n` are low and `reg_sel`, `byte_en` are high, `rdata` is {bit7 busy, bit6 calibration overflow, bit5 supply fail, bit4 0, bit3 power down, bit2 trigger mode, bit1 calibration running, bit0 latch mode}. At all other times `rdata` is 0x00, and this includes a read with `reg_sel` high and `byte_en` low.
- R4: An accepted write with bit 1 = 1 makes `cal_start` high for exactly one cycle after the write edge and clears power down, whatever bit 3 of the write holds.
- R5: A write that has bit 4 or bit 6 set is discarded as a whole: no bit changes, and `cal_start` stays 0.
- R6: The supply-fail flag (bit 5) is set in every cycle where `supply_fail` is high and stays set afterwards. An accepted write with bit 5 = 0 clears it. An accepted write with bit 5 = 1 leaves it set.
- R7: On the cycle after `supply_fail` falls, the latch-mode, trigger-mode and power-down bits and the overflow flag are cleared and `cal_start` pulses for one cycle. The supply-fail flag stays set.
- R8: The calibration-overflow flag (bit 6) is set by a `cal_ovf` pulse and is cleared when a calibration is requested.
- R9: When a flag's set event and its clear fall on the same edge, the set wins. This covers a bit-5 clear write during `supply_fail`, and a calibration request on the same edge as `cal_ovf`.
- R10: Bit 7 reads 1 whenever `cal_busy` or `conv_busy` is high. Bit 1 reads `cal_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write takes effect when it rises |
| reg_sel | input | 1 | Register select; must be high to address this register |
| byte_en | input | 1 | Byte enable; must be high with reg_sel for valid access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when no valid read |
| cal_busy | input | 1 | Sequencer: calibration running |
| conv_busy | input | 1 | Sequencer: conversion running |
| cal_ovf | input | 1 | Sequencer: one-cycle calibration overflow event |
| supply_fail | input | 1 | Supply monitor: supply below threshold |
| latch_mode | output | 1 | 1 = latched output data, 0 = transparent |
| trig_mode | output | 1 | 1 = trigger pin times sample-to-hold, 0 = trigger pin starts calibration |
| pwr_down | output | 1 | Power down request |
| cal_start | output | 1 | One-cycle calibration request to the sequencer |

## Verification
Two pairs of functions can hit the same edge. A write clearing bit 5 can coincide with the supply-fail set, and a calibration request that clears the overflow flag can coincide with a `cal_ovf` pulse. The bench provokes the first by issuing a bit-5 clear write while `supply_fail` is held high. It provokes the second by raising `cal_ovf` in exactly the cycle where the write strobe is seen rising with bit 1 set. In both cases it reads the register back and requires the flag to still be 1, and a later clear without a competing set must bring it to 0.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned B_LATCH    = 0;
  localparam int unsigned B_CAL      = 1;
  localparam int unsigned B_TRIG     = 2;
  localparam int unsigned B_PDN      = 3;
  localparam int unsigned B_RSV      = 4;
  localparam int unsigned B_PFAIL    = 5;
  localparam int unsigned B_CALERR   = 6;
  localparam int unsigned B_BUSY     = 7;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic latch;
    logic trig;
    logic pdn;
  } mode_t;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[DEPTH-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[DEPTH-1];
endmodule

// File: rtl/ccr_bus_decode.sv
module ccr_bus_decode
  import conv_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             reg_sel,
  input  logic             byte_en,
  input  logic [REG_W-1:0] wdata,
  output logic             wr_ok,
  output logic             rd_ok
);
  logic wr_n_q;
  logic wr_rise;
  logic addr_ok;
  logic rsv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n;
  end

  always_comb begin
    wr_rise = !wr_n_q && wr_n && !cs_n;
    addr_ok = reg_sel && byte_en;
    rsv_hit = wdata[B_RSV] || wdata[B_CALERR];
    wr_ok   = wr_rise && addr_ok && !rsv_hit;
    rd_ok   = !cs_n && !rd_n && addr_ok;
  end

  // R2
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (reg_sel && byte_en && !cs_n && $past(!wr_n)));

  // R5
  rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata[B_RSV] || wdata[B_CALERR]) |-> !wr_ok);
endmodule

// File: rtl/ccr_mode_regs.sv
module ccr_mode_regs
  import conv_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wdata,
  input  logic             recov,
  output mode_t            mode,
  output logic             cal_req,
  output logic             cal_start
);
  mode_t mode_q, mode_d;
  logic  mode_en;
  logic  start_q, start_d;

  always_comb begin
    cal_req = (wr_ok && wdata[B_CAL]) || recov;
    mode_en = wr_ok || recov;
    mode_d  = mode_q;
    if (recov) begin
      mode_d = '0;
    end else if (wr_ok) begin
      mode_d.latch = wdata[B_LATCH];
      mode_d.trig  = wdata[B_TRIG];
      mode_d.pdn   = wdata[B_PDN];
    end
    if (cal_req) mode_d.pdn = 1'b0;
    start_d = cal_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      start_q <= start_d;
    end
  end

  assign mode      = mode_q;
  assign cal_start = start_q;

  // R4
  cal_exits_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> !mode_q.pdn);

  // R4
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start && !$past(recov) && !$past(wr_ok && wdata[B_CAL])) |-> 1'b0);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !recov) |=> $stable(mode_q));

  // R7
  recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov |=> (cal_start && mode_q == '0));
endmodule

// File: rtl/ccr_status_flags.sv
module ccr_status_flags
  import conv_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_fail,
  input  logic             cal_ovf,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wdata,
  input  logic             cal_req,
  output logic             recov,
  output logic             pfail,
  output logic             calerr
);
  logic sf_q;
  logic pfail_q, pfail_d;
  logic calerr_q, calerr_d;

  always_comb begin
    recov    = sf_q && !supply_fail;
    pfail_d  = pfail_q;
    if (wr_ok && !wdata[B_PFAIL]) pfail_d = 1'b0;
    if (supply_fail)              pfail_d = 1'b1;
    calerr_d = calerr_q;
    if (cal_req) calerr_d = 1'b0;
    if (cal_ovf) calerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q     <= 1'b0;
      pfail_q  <= 1'b0;
      calerr_q <= 1'b0;
    end else begin
      sf_q     <= supply_fail;
      pfail_q  <= pfail_d;
      calerr_q <= calerr_d;
    end
  end

  assign pfail  = pfail_q;
  assign calerr = calerr_q;

  // R6
  pfail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> pfail_q);

  // R6
  pfail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail_q && !wr_ok) |=> pfail_q);

  // R8
  calerr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ovf |=> calerr_q);

  // R7
  recov_keeps_pfail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov |=> pfail_q);
endmodule

// File: rtl/conv_ctrl_reg.sv
module conv_ctrl_reg
  import conv_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             reg_sel,
  input  logic             byte_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             cal_busy,
  input  logic             conv_busy,
  input  logic             cal_ovf,
  input  logic             supply_fail,
  output logic             latch_mode,
  output logic             trig_mode,
  output logic             pwr_down,
  output logic             cal_start
);
  logic  rst_n_s;
  logic  wr_ok, rd_ok;
  logic  recov, cal_req;
  logic  pfail, calerr;
  mode_t mode;
  logic [REG_W-1:0] status;

  ccr_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ccr_bus_decode u_bus (
    .clk(clk), .rst_n(rst_n_s), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .byte_en(byte_en), .wdata(wdata),
    .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  ccr_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n_s), .wr_ok(wr_ok), .wdata(wdata), .recov(recov),
    .mode(mode), .cal_req(cal_req), .cal_start(cal_start)
  );

  ccr_status_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .supply_fail(supply_fail), .cal_ovf(cal_ovf),
    .wr_ok(wr_ok), .wdata(wdata), .cal_req(cal_req),
    .recov(recov), .pfail(pfail), .calerr(calerr)
  );

  always_comb begin
    status           = '0;
    status[B_LATCH]  = mode.latch;
    status[B_CAL]    = cal_busy;
    status[B_TRIG]   = mode.trig;
    status[B_PDN]    = mode.pdn;
    status[B_PFAIL]  = pfail;
    status[B_CALERR] = calerr;
    status[B_BUSY]   = cal_busy || conv_busy;
    rdata            = rd_ok ? status : '0;
  end

  assign latch_mode = mode.latch;
  assign trig_mode  = mode.trig;
  assign pwr_down   = mode.pdn;

  // R3
  undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_sel && !byte_en) |-> (rdata == '0));

  // R10
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_ok && conv_busy) |-> rdata[B_BUSY]);
endmodule

// File: tb/tb_conv_ctrl_reg.sv
module tb_conv_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n, reg_sel, byte_en;
  logic [7:0] wdata, rdata;
  logic       cal_busy, conv_busy, cal_ovf, supply_fail;
  logic       latch_mode, trig_mode, pwr_down, cal_start;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  conv_ctrl_reg dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .byte_en(byte_en), .wdata(wdata), .rdata(rdata),
    .cal_busy(cal_busy), .conv_busy(conv_busy), .cal_ovf(cal_ovf),
    .supply_fail(supply_fail), .latch_mode(latch_mode), .trig_mode(trig_mode),
    .pwr_down(pwr_down), .cal_start(cal_start)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d, input logic s, input logic b,
                           input logic ovf_at_edge);
    @(negedge clk);
    cs_n = 1'b0; reg_sel = s; byte_en = b; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cal_ovf = ovf_at_edge;
    @(negedge clk);
    cs_n = 1'b1; cal_ovf = 1'b0;
  endtask

  task automatic bus_read(input logic s, input logic b, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; reg_sel = s; byte_en = b;
    #2 d = rdata;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset;
    bus_read(1, 1, rv);
    chk("R1 reset read", rv, 8'h00);
    chk("R1 cal_start idle", {7'd0, cal_start}, 8'h00);
  endtask

  task automatic t_write_decode;
    bus_write(8'h0D, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R2 mode write", rv, 8'h0D);
    chk("R2 pins", {5'd0, pwr_down, trig_mode, latch_mode}, 8'h07);
    bus_write(8'h00, 0, 1, 0);
    bus_read(1, 1, rv);
    chk("R2 reg_sel low ignored", rv, 8'h0D);
    bus_write(8'h00, 1, 0, 0);
    bus_read(1, 1, rv);
    chk("R2 byte_en low ignored", rv, 8'h0D);
    @(negedge clk); reg_sel = 1; byte_en = 1; wdata = 8'h00; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    bus_read(1, 1, rv);
    chk("R2 cs_n high ignored", rv, 8'h0D);
    bus_read(1, 0, rv);
    chk("R3 undefined read returns zero", rv, 8'h00);
    chk("R3 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_reserved;
    bus_write(8'h05, 1, 1, 0);
    bus_write(8'h10, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R5 bit4 write dropped", rv, 8'h05);
    bus_write(8'h42, 1, 1, 0);
    chk("R5 no cal_start", {7'd0, cal_start}, 8'h00);
    bus_read(1, 1, rv);
    chk("R5 bit6 write dropped", rv, 8'h05);
  endtask

  task automatic t_cal_request;
    bus_write(8'h08, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R2 power down set", rv, 8'h08);
    bus_write(8'h0A, 1, 1, 0);
    chk("R4 cal_start pulse", {7'd0, cal_start}, 8'h01);
    chk("R4 power down cleared", {7'd0, pwr_down}, 8'h00);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'd0, cal_start}, 8'h00);
  endtask

  task automatic t_busy;
    bus_write(8'h01, 1, 1, 0);
    cal_busy = 1'b1;
    bus_read(1, 1, rv);
    chk("R10 cal busy", rv, 8'h83);
    cal_busy = 1'b0; conv_busy = 1'b1;
    bus_read(1, 1, rv);
    chk("R10 conv busy", rv, 8'h81);
    conv_busy = 1'b0;
  endtask

  task automatic t_supply;
    @(negedge clk); supply_fail = 1'b1;
    @(negedge clk);
    bus_read(1, 1, rv);
    chk("R6 supply fail flag", rv, 8'h21);
    bus_write(8'h05, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R9 set beats bit5 clear", rv, 8'h25);
    @(negedge clk); supply_fail = 1'b0;
    @(negedge clk);
    chk("R7 recovery cal_start", {7'd0, cal_start}, 8'h01);
    bus_read(1, 1, rv);
    chk("R7 mode reset flag kept", rv, 8'h20);
    bus_write(8'h20, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R6 write one keeps flag", rv, 8'h20);
    bus_write(8'h00, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R6 write zero clears", rv, 8'h00);
  endtask

  task automatic t_calerr;
    @(negedge clk); cal_ovf = 1'b1;
    @(negedge clk); cal_ovf = 1'b0;
    bus_read(1, 1, rv);
    chk("R8 overflow set", rv, 8'h40);
    bus_write(8'h02, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R8 cleared by calibration", rv, 8'h00);
    bus_write(8'h02, 1, 1, 1);
    bus_read(1, 1, rv);
    chk("R9 overflow beats cal clear", rv, 8'h40);
    bus_write(8'h02, 1, 1, 0);
    bus_read(1, 1, rv);
    chk("R8 later clear", rv, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    reg_sel = 1'b0; byte_en = 1'b0; wdata = 8'h00;
    cal_busy = 1'b0; conv_busy = 1'b0; cal_ovf = 1'b0; supply_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_decode();
    t_reserved();
    t_cal_request();
    t_busy();
    t_supply();
    t_calerr();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule